// File: doc/BRIEF.md
# Memory-Descriptor Packet Receive Engine

This engine moves a packet of 16-bit words from a network-side receiver into a buffer in main memory. The buffer is not held in local registers. A control block in memory describes it. The block keeps only the base address of that control block. Each received word therefore costs a pointer read, an end read and a data write, and then a pointer write-back.

Software first issues a control command that loads the control-block base. It then issues a start command. The start checks that the buffer is not empty and opens the receiver. Every word the receiver offers is stored and the pointer advanced. The run ends in one of three ways: on the word flagged as last, on an overflow, or at once for a zero-length buffer. At the end the engine posts a status word to a post address taken from the control block. It then ORs an interrupt-channel mask, also read from the control block, into a sticky pending register.

Control-block layout, in word offsets from the base:

| Offset | Contents |
| --- | --- |
| 0 | Next write address |
| 1 | First address past the buffer |
| 6 | Post address |
| 7 | Interrupt mask |

Top module: `pkt_rx_engine`

## Requirements
- R1: After a synchronous reset `rx_en`, `mem_req` and `irq_pend` are all zero, and `cmd_ready` is one.
- R2: A start command (`cmd_op`=1) accepted before any control command (`cmd_op`=0, `cmd_arg` = base) has been accepted is ignored. No memory request follows and `rx_en` stays 0.
- R3: A start reads base+0 and base+1. If the two values differ, `rx_en` rises and nothing is posted.
- R4: A start whose pointer equals its end posts status 5 (zero length) and leaves `rx_en` at 0.
- R5: A start accepted while a receive is in progress posts status 2 (busy). The receive continues and `rx_en` returns to 1.
- R6: A word accepted while `rx_valid` and `rx_en` are both high is written at the pointer address. The pointer plus one is then written to base+0, and the receiver is re-enabled unless the word is the last.
- R7: If the pointer equals the end when a word arrives, the word is not stored. Status 4 (overflow) is posted, the pointer stays unchanged and `rx_en` stays 0.
- R8: A word with `rx_last`=1 is stored and the pointer is updated. Status 1 (done) is then posted and the receive ends with `rx_en`=0.
- R9: A post reads the post address from base+6. It writes {status[7:0], `hw_status`[7:0]} there, with the status in bits 15:8. It then reads the mask from base+7 and ORs it into `irq_pend`. Bits only accumulate until reset.
- R10: At most one memory request is outstanding. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R11: `cmd_ready` is 0 while a memory sequence runs and in any cycle where a word is being accepted. While a memory sequence runs, `rx_en` is 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 = load control-block base, 1 = start receive |
| cmd_arg | input | AW | Control-block base for cmd_op 0 |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| rx_en | output | 1 | Receiver enabled; a word transfers when rx_valid is also high |
| rx_valid | input | 1 | Receiver offers a word |
| rx_last | input | 1 | Offered word ends the packet |
| rx_data | input | DW | Offered word |
| hw_status | input | 8 | Hardware status placed in the low byte of a post |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| irq_pend | output | DW | Sticky pending interrupt bits |

## Verification
The assertions assume a memory that eventually answers every request. They also assume it raises `mem_ack` for a single cycle, with read data valid in that cycle. The bench model honours both, with a latency that cycles between one and three clocks. The bench further assumes that the receiver offers words only while `rx_en` is high and that `hw_status` stays steady for the length of a receive. The stimulus therefore pulses `rx_valid` only after it has seen `rx_en` high away from the clock edge, and it changes `hw_status` only between cases. A sweep over buffer lengths 0 to 4 and packet lengths 1 to 5 covers the zero-length, exact-fit, last-word and overflow outcomes.

// File: rtl/pkt_rx_engine.sv
module pkt_rx_engine #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [AW-1:0] cmd_arg,
  output logic          cmd_ready,
  output logic          rx_en,
  input  logic          rx_valid,
  input  logic          rx_last,
  input  logic [DW-1:0] rx_data,
  input  logic [7:0]    hw_status,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [DW-1:0] irq_pend
);
  localparam logic [7:0] ST_DONE = 8'd1, ST_BUSY = 8'd2, ST_OVF = 8'd4, ST_ZERO = 8'd5;
  localparam logic [AW-1:0] OFS_END = AW'(1), OFS_POST = AW'(6), OFS_MASK = AW'(7);

  typedef enum logic [2:0] {IDLE, RD_PTR, RD_END, WR_DATA, WR_PTR, RD_PADDR, WR_POST, RD_MASK} st_t;
  st_t state;

  logic [AW-1:0] base, ptr, paddr;
  logic [DW-1:0] word, postw;
  logic [7:0]    stat;
  logic          base_ok, active, is_rx, last;

  wire take_rx  = rx_en & rx_valid;
  wire take_cmd = cmd_valid & cmd_ready;
  wire end_hit  = (AW'(mem_rdata) == ptr);

  assign rx_en     = active & (state == IDLE);
  assign cmd_ready = (state == IDLE) & ~take_rx;
  assign mem_req   = (state != IDLE);
  assign mem_we    = (state == WR_DATA) | (state == WR_PTR) | (state == WR_POST);

  always_comb begin
    mem_addr  = base;
    mem_wdata = '0;
    case (state)
      RD_END:   mem_addr = base + OFS_END;
      WR_DATA:  begin mem_addr = ptr; mem_wdata = word; end
      WR_PTR:   mem_wdata = DW'(ptr + AW'(1));
      RD_PADDR: mem_addr = base + OFS_POST;
      WR_POST:  begin mem_addr = paddr; mem_wdata = postw; end
      RD_MASK:  mem_addr = base + OFS_MASK;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE; base <= '0; base_ok <= 1'b0; active <= 1'b0; is_rx <= 1'b0;
      last <= 1'b0; ptr <= '0; paddr <= '0; word <= '0; postw <= '0; stat <= '0;
      irq_pend <= '0;
    end else begin
      case (state)
        IDLE:
          if (take_rx) begin
            word <= rx_data; last <= rx_last; is_rx <= 1'b1; state <= RD_PTR;
          end else if (take_cmd) begin
            if (!cmd_op) begin
              base <= cmd_arg; base_ok <= 1'b1;
            end else if (base_ok) begin
              is_rx <= 1'b0;
              if (active) begin stat <= ST_BUSY; state <= RD_PADDR; end
              else state <= RD_PTR;
            end
          end
        RD_PTR:  if (mem_ack) begin ptr <= AW'(mem_rdata); state <= RD_END; end
        RD_END:
          if (mem_ack) begin
            if (end_hit) begin
              stat <= is_rx ? ST_OVF : ST_ZERO; active <= 1'b0; state <= RD_PADDR;
            end else if (is_rx) state <= WR_DATA;
            else begin active <= 1'b1; state <= IDLE; end
          end
        WR_DATA: if (mem_ack) state <= WR_PTR;
        WR_PTR:
          if (mem_ack) begin
            if (last) begin stat <= ST_DONE; active <= 1'b0; state <= RD_PADDR; end
            else state <= IDLE;
          end
        RD_PADDR:
          if (mem_ack) begin
            paddr <= AW'(mem_rdata); postw <= DW'({stat, hw_status}); state <= WR_POST;
          end
        WR_POST: if (mem_ack) state <= RD_MASK;
        RD_MASK: if (mem_ack) begin irq_pend <= irq_pend | mem_rdata; state <= IDLE; end
        default: state <= IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_RX_QUIET_MEM: assert property (@(posedge clk) disable iff (rst)
    rx_en |-> !mem_req && cmd_ready != rx_valid || !rx_valid); // R11
  AST_NO_BASE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    take_cmd && cmd_op && !base_ok |=> !mem_req && !rx_en); // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_pend) & ~irq_pend) == '0); // R9
  AST_BUSY_POSTS: assert property (@(posedge clk) disable iff (rst)
    take_cmd && cmd_op && rx_en |=> mem_req && mem_addr == base + OFS_POST); // R5
endmodule

// File: tb/pkt_rx_engine_tb.sv
module pkt_rx_engine_tb;
  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_op = 0, rx_valid = 0, rx_last = 0;
  logic [15:0] cmd_arg = 0, rx_data = 0;
  logic [7:0] hw_status = 0;
  logic cmd_ready, rx_en, mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, irq_pend;

  pkt_rx_engine u_dut (.clk, .rst, .cmd_valid, .cmd_op, .cmd_arg, .cmd_ready, .rx_en,
    .rx_valid, .rx_last, .rx_data, .hw_status, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_ack, .irq_pend);

  logic [15:0] mem [0:255];
  int lat = 0, nacc = 0, nreq = 0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req) nreq <= nreq + 1;
    if (!rst && mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:0]];
        nacc <= nacc + 1;
        lat <= nacc % 3;
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic issue(input logic op, input logic [15:0] arg);
    wait_idle();
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
    wait_idle();
  endtask

  task automatic send(input logic [15:0] d, input logic l);
    @(negedge clk);
    while (!rx_en) @(negedge clk);
    rx_valid = 1; rx_data = d; rx_last = l;
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    wait_idle();
  endtask

  localparam logic [15:0] BASE = 16'h10, BUF = 16'h40;
  logic [15:0] irq_exp = 0;

  initial begin
    fork
      begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 0;
        chk("R1 rx_en", rx_en, 0); chk("R1 mem_req", mem_req, 0);
        chk("R1 irq", irq_pend, 0); chk("R1 ready", cmd_ready, 1);
        issue(1'b1, 16'h0);
        repeat (6) @(negedge clk);
        chk("R2 no request", nreq, 0); chk("R2 rx_en", rx_en, 0);
        issue(1'b0, BASE);
        for (int len = 0; len <= 4; len++)
          for (int n = 1; n <= 5; n++) begin
            automatic int k = (len * 5 + n) % 16;
            automatic logic [15:0] paddr = 16'h20 + 16'(k);
            automatic int stored = (n <= len) ? n : len;
            automatic logic [7:0] st = (len == 0) ? 8'd5 : ((n <= len) ? 8'd1 : 8'd4);
            hw_status = 8'((len * 5 + n) * 7);
            mem[BASE] = BUF; mem[BASE + 1] = BUF + 16'(len);
            mem[BASE + 6] = paddr; mem[BASE + 7] = 16'h1 << k;
            mem[paddr] = 16'h0;
            for (int a = 0; a < 8; a++) mem[BUF + a] = 16'hDEAD;
            issue(1'b1, 16'h0);
            if (len == 0) chk("R4 rx_en stays low", rx_en, 0);
            else begin
              chk("R3 rx_en", rx_en, 1); chk("R3 no post", mem[paddr], 0);
              if (len == 2 && n == 2) begin
                issue(1'b1, 16'h0);
                chk("R5 busy post", mem[paddr], {8'd2, hw_status});
                chk("R5 rx_en back", rx_en, 1);
                mem[paddr] = 16'h0;
              end
              for (int i = 0; i < n; i++) begin
                if (rx_en) send(16'h1000 * 16'(n) + 16'(i) + 16'(len << 8), (i == n - 1));
                if (i < n - 1 && i < len)
                  chk("R6 pointer advanced", mem[BASE], BUF + 16'(i + 1));
              end
            end
            irq_exp |= 16'h1 << k;
            chk(st == 8'd4 ? "R7 post" : (st == 8'd1 ? "R8 post" : "R4 post"),
                mem[paddr], {st, hw_status});
            chk("R6 final pointer", mem[BASE], BUF + 16'(stored));
            for (int i = 0; i < stored; i++)
              chk("R6 stored word", mem[BUF + i], 16'h1000 * 16'(n) + 16'(i) + 16'(len << 8));
            chk("R7 nothing past data", mem[BUF + stored], 16'hDEAD);
            chk("R8 receive ended", rx_en, 0);
            chk("R9 irq accumulated", irq_pend, irq_exp);
          end
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        chk("R1 irq after reset", irq_pend, 0); chk("R1 rx_en after reset", rx_en, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule